// File: doc/BRIEF.md
# Trace Synchronization Interval Scheduler

This block belongs to a trace packet exporter. It decides when the exporter must insert a synchronization sequence into the outgoing stream. A 32-bit configuration word holds a period field and a mode bit. The period is either a plain byte count or a power of two whose exponent comes from the upper bits of the field. The block adds up the bytes that leave on the trace output. When the total reaches the period, it asks for a sync.

Every sync is sent as a fixed three-packet preamble: an alignment marker, then a version packet, then a master/channel context packet. The block offers these one at a time on a valid/ready request port. It holds data traffic off with `data_ready` until the context packet has been taken. A sync can start in three ways: the period expiring, a write to the configuration word, or an external request. If a second start arrives while a preamble is already under way, it joins that preamble rather than starting a new one. A one-cycle flag marks the start of each sequence, so the exporter knows the master context is being sent again.

Top module: `trace_sync_sched`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x0000_1780: the mode bit (bit 12) is 1 and the period field (bits 11:0) is 0x780. A write stores bit 12 and bits 11:0. Bits 31:13 always read zero.
- R2: In mode 0 the period is the field value in bytes. `pkt_req_valid` goes high with type ASYNC on the second rising edge after the byte input that brings the total to, or past, the period. It stays low while the total is below the period.
- R3: In mode 1 the period is 2^N bytes, where N is bits 11:7 of the field. With the reset value, N is 15 and the period is 32768 bytes.
- R4: In mode 1, an exponent below 12 is treated as 12 and an exponent above 27 is treated as 27.
- R5: A period field of zero turns off the periodic sync in either mode, however many bytes pass.
- R6: Any register write starts a sync: `pkt_req_valid` is high with type ASYNC on the next edge. The byte total restarts from zero.
- R7: A one-cycle `ext_sync_req` while idle starts a sync on the next edge, even when the periodic sync is off.
- R8: Each sync issues exactly three packets, in this order: type 0 (ASYNC), type 1 (VERSION), type 2 (MASTER).
- R9: While `pkt_ready` is low, `pkt_req_valid` stays high and `pkt_req_type` holds its value.
- R10: `data_ready` is low from the edge that starts a sequence until the edge that accepts the MASTER packet. It is high otherwise.
- R11: `master_switch` is high for exactly one cycle, the first cycle of each sequence, while ASYNC is requested.
- R12: A write or an external request that arrives during a preamble adds no packets and does not restart the order.
- R13: The byte total clears on the edge that accepts ASYNC. Bytes counted before that edge do not count toward the next period.
- R14: A register write in the same cycle as a period expiry produces a single preamble. The next period then uses the newly written value, counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write value |
| cfg_rd_data | output | 32 | Current configuration word |
| byte_valid | input | 1 | Bytes left the trace output this cycle |
| byte_count | input | 3 | Number of bytes that left this cycle |
| ext_sync_req | input | 1 | Sync request from another source |
| pkt_ready | input | 1 | Downstream accepts the requested packet |
| pkt_req_valid | output | 1 | A preamble packet is requested |
| pkt_req_type | output | 2 | 0 ASYNC, 1 VERSION, 2 MASTER |
| data_ready | output | 1 | Data packets may be sent |
| master_switch | output | 1 | One-cycle pulse at the start of each sequence |

## Verification
Two starts can fall in the same cycle. The bench provokes the most delicate case by driving a configuration write on the very cycle the byte total reaches the period. It then checks that the scoreboard receives only one preamble. It also checks that the next sync arrives exactly one new period later, counted from zero. A second collision comes from pulsing an external request and rewriting the register while a held-off preamble is in progress. Here the checks are that no extra packets appear and that the packet order does not restart.

// File: rtl/trace_sync_pkg.sv
package trace_sync_pkg;
  localparam int PKT_KIND_W = 2;

  typedef enum logic [PKT_KIND_W-1:0] {
    PKT_ASYNC   = 2'd0,
    PKT_VERSION = 2'd1,
    PKT_MASTER  = 2'd2
  } pkt_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ASYNC,
    SQ_VERSION,
    SQ_MASTER
  } seq_state_e;
endpackage

// File: rtl/trace_sync_cfg.sv
module trace_sync_cfg #(
  parameter int REG_W    = 32,
  parameter int CNT_W    = 12,
  parameter int MODE_POS = 12,
  parameter int EXP_LSB  = 7,
  parameter int EXP_W    = 5,
  parameter int MIN_EXP  = 12,
  parameter int MAX_EXP  = 27,
  parameter logic RST_MODE = 1'b1,
  parameter logic [CNT_W-1:0] RST_COUNT = 12'h780,
  parameter int PER_W    = MAX_EXP + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [PER_W-1:0] period,
  output logic             period_on
);
  logic             mode_q;
  logic [CNT_W-1:0] count_q;
  logic             unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:MODE_POS+1];

  // Period is worked out once, when the word is written.
  function automatic logic [PER_W-1:0] period_of(input logic m, input logic [CNT_W-1:0] c);
    logic [EXP_W-1:0] e;
    int n;
    e = c[EXP_LSB +: EXP_W];
    if (!m) begin
      period_of = PER_W'(c);
    end else begin
      n = int'(e);
      if (n < MIN_EXP) n = MIN_EXP;
      if (n > MAX_EXP) n = MAX_EXP;
      period_of = PER_W'(1) << n;
    end
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= RST_MODE;
      count_q   <= RST_COUNT;
      period    <= period_of(RST_MODE, RST_COUNT);
      period_on <= (RST_COUNT != '0);
    end else if (wr_en) begin
      mode_q    <= wr_data[MODE_POS];
      count_q   <= wr_data[CNT_W-1:0];
      period    <= period_of(wr_data[MODE_POS], wr_data[CNT_W-1:0]);
      period_on <= |wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_data               = '0;
    rd_data[CNT_W-1:0]    = count_q;
    rd_data[MODE_POS]     = mode_q;
  end
endmodule

// File: rtl/trace_sync_bytecnt.sv
module trace_sync_bytecnt #(
  parameter int PER_W  = 28,
  parameter int BYTE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_en,
  input  logic [BYTE_W-1:0] add_bytes,
  input  logic              clear,
  input  logic [PER_W-1:0]  period,
  input  logic              period_on,
  output logic              hit
);
  localparam int ACC_W = PER_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic             carry;

  assign {carry, acc_sum} = {1'b0, acc_q} + {{(ACC_W + 1 - BYTE_W){1'b0}}, add_bytes};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (add_en) begin
      acc_q <= carry ? '1 : acc_sum;
    end
  end

  assign hit = period_on && (acc_q >= ACC_W'(period));
endmodule

// File: rtl/trace_sync_seq.sv
module trace_sync_seq
  import trace_sync_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trigger,
  input  logic                  pkt_ready,
  output logic                  pkt_valid,
  output logic [PKT_KIND_W-1:0] pkt_type,
  output logic                  data_ready,
  output logic                  master_switch,
  output logic                  async_taken
);
  seq_state_e state_q;
  logic       ms_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      ms_q    <= 1'b0;
    end else begin
      ms_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (trigger) begin
            state_q <= SQ_ASYNC;
            ms_q    <= 1'b1;
          end
        end
        SQ_ASYNC:   if (pkt_ready) state_q <= SQ_VERSION;
        SQ_VERSION: if (pkt_ready) state_q <= SQ_MASTER;
        default:    if (pkt_ready) state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      SQ_VERSION: pkt_type = PKT_VERSION;
      SQ_MASTER:  pkt_type = PKT_MASTER;
      default:    pkt_type = PKT_ASYNC;
    endcase
  end

  assign pkt_valid     = (state_q != SQ_IDLE);
  assign data_ready    = (state_q == SQ_IDLE);
  assign master_switch = ms_q;
  assign async_taken   = (state_q == SQ_ASYNC) && pkt_ready;
endmodule

// File: rtl/trace_sync_sched.sv
module trace_sync_sched
  import trace_sync_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int CNT_W    = 12,
  parameter int MODE_POS = 12,
  parameter int EXP_LSB  = 7,
  parameter int EXP_W    = 5,
  parameter int MIN_EXP  = 12,
  parameter int MAX_EXP  = 27,
  parameter int BYTE_W   = 3,
  parameter logic RST_MODE = 1'b1,
  parameter logic [CNT_W-1:0] RST_COUNT = 12'h780
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wr_en,
  input  logic [REG_W-1:0]      cfg_wr_data,
  output logic [REG_W-1:0]      cfg_rd_data,
  input  logic                  byte_valid,
  input  logic [BYTE_W-1:0]     byte_count,
  input  logic                  ext_sync_req,
  input  logic                  pkt_ready,
  output logic                  pkt_req_valid,
  output logic [PKT_KIND_W-1:0] pkt_req_type,
  output logic                  data_ready,
  output logic                  master_switch
);
  localparam int PER_W = MAX_EXP + 1;

  logic [PER_W-1:0] period;
  logic             period_on;
  logic             period_hit;
  logic             async_taken;
  logic             start_sync;
  logic             clear_cnt;

  trace_sync_cfg #(
    .REG_W(REG_W), .CNT_W(CNT_W), .MODE_POS(MODE_POS), .EXP_LSB(EXP_LSB),
    .EXP_W(EXP_W), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP),
    .RST_MODE(RST_MODE), .RST_COUNT(RST_COUNT), .PER_W(PER_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .period(period), .period_on(period_on)
  );

  assign clear_cnt  = cfg_wr_en | async_taken;
  assign start_sync = cfg_wr_en | ext_sync_req | period_hit;

  trace_sync_bytecnt #(.PER_W(PER_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .add_en(byte_valid), .add_bytes(byte_count),
    .clear(clear_cnt), .period(period), .period_on(period_on), .hit(period_hit)
  );

  trace_sync_seq u_seq (
    .clk(clk), .rst(rst), .trigger(start_sync), .pkt_ready(pkt_ready),
    .pkt_valid(pkt_req_valid), .pkt_type(pkt_req_type),
    .data_ready(data_ready), .master_switch(master_switch),
    .async_taken(async_taken)
  );
endmodule

// File: rtl/trace_sync_sched_chk.sv
module trace_sync_sched_chk
  import trace_sync_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int MODE_POS = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_wr_en,
  input logic [REG_W-1:0]      cfg_rd_data,
  input logic                  ext_sync_req,
  input logic                  pkt_ready,
  input logic                  pkt_req_valid,
  input logic [PKT_KIND_W-1:0] pkt_req_type,
  input logic                  data_ready,
  input logic                  master_switch
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_data[REG_W-1:MODE_POS+1] == '0);

  a_r6_write_starts: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en && data_ready |=> pkt_req_valid && pkt_req_type == PKT_ASYNC && master_switch);

  a_r7_ext_starts: assert property (@(posedge clk) disable iff (rst)
    ext_sync_req && data_ready |=> pkt_req_valid && master_switch);

  a_r8_async_then_version: assert property (@(posedge clk) disable iff (rst)
    pkt_req_valid && pkt_ready && pkt_req_type == PKT_ASYNC |=> pkt_req_valid && pkt_req_type == PKT_VERSION);

  a_r8_version_then_master: assert property (@(posedge clk) disable iff (rst)
    pkt_req_valid && pkt_ready && pkt_req_type == PKT_VERSION |=> pkt_req_valid && pkt_req_type == PKT_MASTER);

  a_r10_master_releases: assert property (@(posedge clk) disable iff (rst)
    pkt_req_valid && pkt_ready && pkt_req_type == PKT_MASTER |=> !pkt_req_valid && data_ready);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    pkt_req_valid && !pkt_ready |=> pkt_req_valid && $stable(pkt_req_type));

  a_r10_data_blocked: assert property (@(posedge clk) disable iff (rst)
    pkt_req_valid |-> !data_ready);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    master_switch |=> !master_switch);

  a_r11_with_async: assert property (@(posedge clk) disable iff (rst)
    master_switch |-> pkt_req_valid && pkt_req_type == PKT_ASYNC);

  a_r12_no_restart: assert property (@(posedge clk) disable iff (rst)
    pkt_req_valid && pkt_req_type != PKT_ASYNC |=> !(pkt_req_valid && pkt_req_type == PKT_ASYNC));
endmodule

bind trace_sync_sched trace_sync_sched_chk #(.REG_W(REG_W), .MODE_POS(MODE_POS)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_data(cfg_rd_data),
  .ext_sync_req(ext_sync_req), .pkt_ready(pkt_ready), .pkt_req_valid(pkt_req_valid),
  .pkt_req_type(pkt_req_type), .data_ready(data_ready), .master_switch(master_switch)
);

// File: tb/trace_sync_sched_test.sv
module trace_sync_sched_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        byte_valid = 1'b0;
  logic [2:0]  byte_count = '0;
  logic        ext_sync_req = 1'b0;
  logic        pkt_ready = 1'b1;
  logic        pkt_req_valid;
  logic [1:0]  pkt_req_type;
  logic        data_ready;
  logic        master_switch;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_sync_sched uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .byte_valid(byte_valid), .byte_count(byte_count),
    .ext_sync_req(ext_sync_req), .pkt_ready(pkt_ready), .pkt_req_valid(pkt_req_valid),
    .pkt_req_type(pkt_req_type), .data_ready(data_ready), .master_switch(master_switch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_preamble();
    exp_q.push_back(0);
    exp_q.push_back(1);
    exp_q.push_back(2);
  endtask

  // Drives bytes for a number of cycles; returns one negedge after the last drive.
  task automatic run_bytes(input int per, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      byte_valid = 1'b1;
      byte_count = 3'(per);
      tick();
    end
    byte_valid = 1'b0;
    byte_count = '0;
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    push_preamble();
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_preamble(input string req);
    for (int i = 0; i < 64 && (exp_q.size() != 0 || pkt_req_valid); i++) tick();
    chk({req, " preamble drained"}, 32'(exp_q.size()), 0);
    chk({req, " data_ready after MASTER"}, 32'(data_ready), 1);
  endtask

  // Called at the negedge after bytes were counted.
  task automatic expect_sync(input string req, input bit yes);
    chk({req, " no launch before second edge"}, 32'(pkt_req_valid), 0);
    tick();
    chk({req, " launch"}, 32'(pkt_req_valid), 32'(yes));
    if (yes) begin
      chk({req, " first packet ASYNC"}, 32'(pkt_req_type), 0);
      chk("R11 master_switch at start", 32'(master_switch), 1);
      chk("R10 data_ready low at start", 32'(data_ready), 0);
    end
  endtask

  // Scoreboard monitor: compares accepted packets with the expected queue.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && pkt_req_valid && pkt_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8/R12: actual unexpected packet type %0d expected none", pkt_req_type);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (int'(pkt_req_type) != e) begin
            errors++;
            $display("FAIL R8: actual type %0d expected %0d", pkt_req_type, e);
          end
        end
        checks++;
        if (data_ready) begin
          errors++;
          $display("FAIL R10: actual data_ready 1 expected 0 during preamble");
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 reset readback", cfg_rd_data, 32'h0000_1780);
    chk("R1 no request after reset", 32'(pkt_req_valid), 0);
    chk("R10 data_ready after reset", 32'(data_ready), 1);
    chk("R11 no pulse after reset", 32'(master_switch), 0);

    // R3: reset period is 2^15 bytes
    run_bytes(7, 4681);
    expect_sync("R3 32767 bytes", 1'b0);
    push_preamble();
    run_bytes(1, 1);
    expect_sync("R3 32768 bytes", 1'b1);
    tick();
    chk("R11 pulse is one cycle", 32'(master_switch), 0);
    wait_preamble("R8");

    // R6 + R1: write mode 0 period 10 with reserved bits set
    cfg_write(32'hFFFF_E00A);
    chk("R6 write launches", 32'(pkt_req_valid), 1);
    chk("R6 write ASYNC", 32'(pkt_req_type), 0);
    chk("R1 reserved bits read zero", cfg_rd_data, 32'h0000_000A);
    wait_preamble("R6");

    // R2: linear period, exact and overshoot
    run_bytes(3, 3);
    expect_sync("R2 9 of 10 bytes", 1'b0);
    push_preamble();
    run_bytes(1, 1);
    expect_sync("R2 exact 10 bytes", 1'b1);
    wait_preamble("R2");
    push_preamble();
    run_bytes(7, 2);
    expect_sync("R2 overshoot 14 bytes", 1'b1);
    wait_preamble("R2");

    // R13 + R7: external sync clears the partial total
    run_bytes(3, 2);
    ext_sync_req = 1'b1;
    push_preamble();
    tick();
    ext_sync_req = 1'b0;
    chk("R7 external launch", 32'(pkt_req_valid), 1);
    wait_preamble("R7");
    run_bytes(3, 3);
    expect_sync("R13 total restarted at ASYNC", 1'b0);
    push_preamble();
    run_bytes(1, 1);
    expect_sync("R13 full period after restart", 1'b1);
    wait_preamble("R13");

    // R9 + R12: back-pressure, merged requests during preamble
    pkt_ready = 1'b0;
    ext_sync_req = 1'b1;
    push_preamble();
    tick();
    ext_sync_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R9 ASYNC held", 32'(pkt_req_valid), 1);
      chk("R9 type stable", 32'(pkt_req_type), 0);
      ext_sync_req = (i == 1);
      tick();
    end
    ext_sync_req = 1'b0;
    pkt_ready = 1'b1;
    tick();
    pkt_ready = 1'b0;
    chk("R12 moved to VERSION", 32'(pkt_req_type), 1);
    cfg_wr_en = 1'b1;
    cfg_wr_data = 32'h0000_000A;
    tick();
    cfg_wr_en = 1'b0;
    tick();
    chk("R12 write merged, still VERSION", 32'(pkt_req_type), 1);
    chk("R9 VERSION held", 32'(pkt_req_valid), 1);
    pkt_ready = 1'b1;
    wait_preamble("R12");
    tick();
    tick();
    chk("R12 no second sequence", 32'(pkt_req_valid), 0);

    // R14: write in the same cycle as period expiry
    run_bytes(7, 1);
    run_bytes(3, 1);
    cfg_write(32'h0000_0005);
    chk("R14 single launch", 32'(pkt_req_valid), 1);
    chk("R14 new value", cfg_rd_data, 32'h0000_0005);
    wait_preamble("R14");
    tick();
    tick();
    chk("R14 no second sequence", 32'(pkt_req_valid), 0);
    run_bytes(1, 4);
    expect_sync("R14 4 of 5 bytes", 1'b0);
    push_preamble();
    run_bytes(1, 1);
    expect_sync("R14 new period from zero", 1'b1);
    wait_preamble("R14");

    // R4: exponent 3 clamps to 12
    cfg_write(32'h0000_1180);
    wait_preamble("R4");
    chk("R4 readback", cfg_rd_data, 32'h0000_1180);
    run_bytes(7, 585);
    expect_sync("R4 low clamp 4095 bytes", 1'b0);
    push_preamble();
    run_bytes(1, 1);
    expect_sync("R4 low clamp 4096 bytes", 1'b1);
    wait_preamble("R4");

    // R3: exponent 13
    cfg_write(32'h0000_1680);
    wait_preamble("R3");
    run_bytes(7, 1170);
    expect_sync("R3 8190 of 8192 bytes", 1'b0);
    push_preamble();
    run_bytes(2, 1);
    expect_sync("R3 8192 bytes", 1'b1);
    wait_preamble("R3");

    // R4: exponent 31 clamps to 27, so no early sync
    cfg_write(32'h0000_1F80);
    wait_preamble("R4");
    run_bytes(7, 4000);
    expect_sync("R4 high clamp no early sync", 1'b0);

    // R5: zero period disables, R7 external still works
    cfg_write(32'h0000_0000);
    wait_preamble("R5");
    chk("R5 readback zero", cfg_rd_data, 32'h0);
    run_bytes(7, 100);
    expect_sync("R5 mode 0 disabled", 1'b0);
    ext_sync_req = 1'b1;
    push_preamble();
    tick();
    ext_sync_req = 1'b0;
    chk("R7 external while disabled", 32'(pkt_req_valid), 1);
    wait_preamble("R7");
    cfg_write(32'h0000_1000);
    wait_preamble("R5");
    run_bytes(7, 1000);
    expect_sync("R5 mode 1 disabled", 1'b0);

    tick();
    chk("R8 scoreboard empty", 32'(exp_q.size()), 0);
    done = 1'b1;
    summary();
  end
endmodule